// File: doc/BRIEF.md
# Panel Configuration Serial Register Slave

This block sits on the panel side of a write-only serial configuration port. A host shifts 16-bit command words into it, most significant bit first. A word is framed by an active-low select line, and data is taken on the rising edge of a serial clock that idles low. The block runs on its own system clock and oversamples the serial lines through synchronizers, so the serial clock must be several times slower than the system clock.

Each completed word is split into three fields: a 6-bit register address in the top bits, a write flag, and a data byte in the low bits. The word updates a small register file. The block drives the decoded settings as plain control outputs: scan mode, pixel-clock and sync polarity, the power and pump enables, horizontal and vertical flip, and the pump rates. It also drives twelve 10-bit gamma points. Each point is built from two parts: its upper two bits are packed four to a register, and its lower byte has a register of its own.

Top module: `panelCfgSlave`

## Requirements
- R1: A word is 16 bits, taken on rising serial-clock edges while the select is low, first bit = word bit 15. Bits 15:10 are the address, bit 8 is the write flag (1 = write), bits 7:0 are the data, and bit 9 has no effect.
- R2: Address 2 sets the timing register. Data bits 2:0 drive `scanMode`, bit 3 drives `pclkRising`, bit 4 drives `hsyncHigh` and bit 5 drives `vsyncHigh`.
- R3: Address 3 sets the power register. The data bits map to the outputs as follows: 0 = `notStandby`, 1 = `cpClkEn`, 2 = `vglPumpEn`, 3 = `pwmEn`, 4 = `fullDrive`, 6 = `preChargeEn`, 7 = `softCtl`.
- R4: Address 4 sets the orientation register. `hFlip` is the inverse of data bit 0 and `vFlip` is the inverse of data bit 1. Bit 2 drives `cpClkLineRate` and bit 4 drives `vglLineRate`.
- R5: Addresses 0x11, 0x12 and 0x13 hold bits 9:8 of gamma points 0-3, 4-7 and 8-11. Point i of a group sits at data bits [7-2i:6-2i].
- R6: Addresses 0x14 to 0x1F hold bits 7:0 of gamma points 0 to 11, in that order. Point k appears on `gammaPts[10k+9:10k]`.
- R7: A complete word whose write flag is 0 changes no output.
- R8: If the select rises before 16 bits have arrived, the partial word is discarded and no output changes. The next word is counted from its first bit.
- R9: While `rstN` is low, and after it rises, the outputs are: `scanMode` = 7, other timing bits 0, the power register = 0xD0, no flip, line-rate bits 0, and every gamma point 0.
- R10: A write to any address other than 2, 3, 4 or 0x11 to 0x1F changes no output.
- R11: Clock edges after the 16th within one select-low period are ignored. Only the first 16 bits form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| csN | input | 1 | Active-low word select |
| mosi | input | 1 | Serial data in |
| scanMode | output | 3 | Scan mode select |
| pclkRising | output | 1 | Pixel clock rising-edge select |
| hsyncHigh | output | 1 | Horizontal sync active high |
| vsyncHigh | output | 1 | Vertical sync active high |
| notStandby | output | 1 | Out of standby |
| cpClkEn | output | 1 | Charge-pump clock enable |
| vglPumpEn | output | 1 | Negative gate pump enable |
| pwmEn | output | 1 | PWM enable |
| fullDrive | output | 1 | Full drive strength |
| preChargeEn | output | 1 | Pre-charge enable |
| softCtl | output | 1 | Software control select |
| hFlip | output | 1 | Horizontal flip active |
| vFlip | output | 1 | Vertical flip active |
| cpClkLineRate | output | 1 | Charge-pump clock at line rate |
| vglLineRate | output | 1 | Negative gate pump at line rate |
| gammaPts | output | 120 | Twelve 10-bit gamma points, point 0 in the low bits |

## Verification
The assertions check the framing invariants on every cycle. The bit counter never passes 16, and it is cleared whenever the select is seen high. Each word produces at most a one-cycle write strobe. No register or gamma output moves in a cycle without a strobe, and a timing-register write appears on the outputs one cycle later. The bench scenarios are the only place where the rest can be shown. These are the field positions of each register, the split gamma assembly, and the defaults after a second reset. They also include discarded words: flag clear, cut short, unmapped addresses, and trailing extra clock edges. Such cases can only be seen as outputs that stay unchanged across a whole word.

// File: rtl/panelCfg_pkg.sv
package panelCfg_pkg;
  localparam int FRAME_W   = 16;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int WFLAG_POS = 8;

  localparam int ADDR_TIMING = 2;
  localparam int ADDR_POWER  = 3;
  localparam int ADDR_ORIENT = 4;
  localparam int ADDR_GHI    = 'h11;
  localparam int ADDR_GLO    = 'h14;

  localparam logic [DATA_W-1:0] TIMING_RST = 8'h07;
  localparam logic [DATA_W-1:0] POWER_RST  = 8'hD0;
  localparam logic [DATA_W-1:0] ORIENT_RST = 8'h03;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cfgStb_t;
endpackage

// File: rtl/panelCfgFrameCtrl.sv
module panelCfgFrameCtrl
  import panelCfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    mosi,
  output cfgStb_t stb
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic                   sclkPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic [FRAME_W-2:0]     shiftReg;
  logic                   sclkS, csS, mosiS, sclkRise, lastBit;
  logic [FRAME_W-1:0]     word;
  logic                   unusedBit9;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign csS      = csSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPrev & ~csS;
  assign lastBit  = (bitCnt == CNT_W'(FRAME_W - 1));
  assign word     = {shiftReg, mosiS};
  assign unusedBit9 = word[WFLAG_POS+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      stb      <= '0;
    end else begin
      stb.wrEn <= 1'b0;
      if (csS) begin
        bitCnt <= '0;
      end else if (sclkRise && bitCnt < CNT_W'(FRAME_W)) begin
        shiftReg <= word[FRAME_W-2:0];
        bitCnt   <= bitCnt + 1'b1;
        if (lastBit) begin
          stb.wrEn <= word[WFLAG_POS];
          stb.addr <= word[FRAME_W-1 -: ADDR_W];
          stb.data <= word[DATA_W-1:0];
        end
      end
    end
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W));

  // R8
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0));

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> !stb.wrEn);
endmodule

// File: rtl/panelCfgRegFile.sv
module panelCfgRegFile
  import panelCfg_pkg::*;
#(
  parameter int NUM_GAMMA = 12,
  parameter int GAMMA_W   = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cfgStb_t                      stb,
  output logic [DATA_W-1:0]            timingReg,
  output logic [DATA_W-1:0]            powerReg,
  output logic [DATA_W-1:0]            orientReg,
  output logic [NUM_GAMMA*GAMMA_W-1:0] gammaPts
);
  localparam int HI_W   = GAMMA_W - DATA_W;
  localparam int PTS_HI = DATA_W / HI_W;
  localparam int NUM_HI = (NUM_GAMMA + PTS_HI - 1) / PTS_HI;

  logic [DATA_W-1:0] gHi [NUM_HI];
  logic [DATA_W-1:0] gLo [NUM_GAMMA];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timingReg <= TIMING_RST;
      powerReg  <= POWER_RST;
      orientReg <= ORIENT_RST;
      for (int h = 0; h < NUM_HI; h++) gHi[h] <= '0;
      for (int k = 0; k < NUM_GAMMA; k++) gLo[k] <= '0;
    end else if (stb.wrEn) begin
      if (stb.addr == ADDR_W'(ADDR_TIMING)) timingReg <= stb.data;
      if (stb.addr == ADDR_W'(ADDR_POWER))  powerReg  <= stb.data;
      if (stb.addr == ADDR_W'(ADDR_ORIENT)) orientReg <= stb.data;
      for (int h = 0; h < NUM_HI; h++)
        if (stb.addr == ADDR_W'(ADDR_GHI + h)) gHi[h] <= stb.data;
      for (int k = 0; k < NUM_GAMMA; k++)
        if (stb.addr == ADDR_W'(ADDR_GLO + k)) gLo[k] <= stb.data;
    end
  end

  for (genvar g = 0; g < NUM_GAMMA; g++) begin : gAsm
    assign gammaPts[g*GAMMA_W +: GAMMA_W] =
      {gHi[g/PTS_HI][DATA_W-1-HI_W*(g%PTS_HI) -: HI_W], gLo[g]};
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> ($stable(timingReg) && $stable(powerReg) &&
                   $stable(orientReg) && $stable(gammaPts)));

  // R2
  timing_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.addr == ADDR_W'(ADDR_TIMING)) |=> (timingReg == $past(stb.data)));
endmodule

// File: rtl/panelCfgSlave.sv
module panelCfgSlave
  import panelCfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_GAMMA   = 12,
  parameter int GAMMA_W     = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sclk,
  input  logic                         csN,
  input  logic                         mosi,
  output logic [2:0]                   scanMode,
  output logic                         pclkRising,
  output logic                         hsyncHigh,
  output logic                         vsyncHigh,
  output logic                         notStandby,
  output logic                         cpClkEn,
  output logic                         vglPumpEn,
  output logic                         pwmEn,
  output logic                         fullDrive,
  output logic                         preChargeEn,
  output logic                         softCtl,
  output logic                         hFlip,
  output logic                         vFlip,
  output logic                         cpClkLineRate,
  output logic                         vglLineRate,
  output logic [NUM_GAMMA*GAMMA_W-1:0] gammaPts
);
  cfgStb_t           stb;
  logic [DATA_W-1:0] timingReg, powerReg, orientReg;
  logic              unusedFields;

  panelCfgFrameCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .stb(stb));

  panelCfgRegFile #(.NUM_GAMMA(NUM_GAMMA), .GAMMA_W(GAMMA_W)) regs_i (
    .clk(clk), .rstN(rstN), .stb(stb), .timingReg(timingReg),
    .powerReg(powerReg), .orientReg(orientReg), .gammaPts(gammaPts));

  assign scanMode      = timingReg[2:0];
  assign pclkRising    = timingReg[3];
  assign hsyncHigh     = timingReg[4];
  assign vsyncHigh     = timingReg[5];
  assign notStandby    = powerReg[0];
  assign cpClkEn       = powerReg[1];
  assign vglPumpEn     = powerReg[2];
  assign pwmEn         = powerReg[3];
  assign fullDrive     = powerReg[4];
  assign preChargeEn   = powerReg[6];
  assign softCtl       = powerReg[7];
  assign hFlip         = ~orientReg[0];
  assign vFlip         = ~orientReg[1];
  assign cpClkLineRate = orientReg[2];
  assign vglLineRate   = orientReg[4];
  assign unusedFields  = ^{timingReg[7:6], powerReg[5], orientReg[3], orientReg[7:5]};
endmodule

// File: tb/panelCfgSlave_tb_top.sv
module panelCfgSlave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 3;
  localparam int NG = 12;
  localparam int GW = 10;

  typedef struct packed {
    logic [2:0]       scan;
    logic [2:0]       pol;
    logic [6:0]       pwr;
    logic [3:0]       orient;
    logic [NG*GW-1:0] gam;
  } obs_t;

  logic clk = 0, rstN = 0, sclk = 0, csN = 1, mosi = 0;
  logic [2:0] scanMode;
  logic pclkRising, hsyncHigh, vsyncHigh, notStandby, cpClkEn, vglPumpEn, pwmEn;
  logic fullDrive, preChargeEn, softCtl, hFlip, vFlip, cpClkLineRate, vglLineRate;
  logic [NG*GW-1:0] gammaPts;

  int nTests = 0, nFail = 0;
  bit done = 0;
  logic [7:0] m2, m3, m4;
  logic [7:0] mHi [3];
  logic [7:0] mLo [NG];
  obs_t  expQ [$];
  string tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  panelCfgSlave dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .scanMode(scanMode), .pclkRising(pclkRising), .hsyncHigh(hsyncHigh),
    .vsyncHigh(vsyncHigh), .notStandby(notStandby), .cpClkEn(cpClkEn),
    .vglPumpEn(vglPumpEn), .pwmEn(pwmEn), .fullDrive(fullDrive),
    .preChargeEn(preChargeEn), .softCtl(softCtl), .hFlip(hFlip), .vFlip(vFlip),
    .cpClkLineRate(cpClkLineRate), .vglLineRate(vglLineRate), .gammaPts(gammaPts));

  function automatic obs_t modelObs();
    obs_t o;
    o.scan   = m2[2:0];
    o.pol    = {m2[5], m2[4], m2[3]};
    o.pwr    = {m3[7], m3[6], m3[4], m3[3], m3[2], m3[1], m3[0]};
    o.orient = {m4[4], m4[2], ~m4[1], ~m4[0]};
    for (int k = 0; k < NG; k++) begin
      logic [1:0] hi;
      hi = 2'((mHi[k/4] >> (6 - 2*(k%4))) & 8'h3);
      o.gam[k*GW +: GW] = {hi, mLo[k]};
    end
    return o;
  endfunction

  function automatic obs_t dutObs();
    obs_t o;
    o.scan   = scanMode;
    o.pol    = {vsyncHigh, hsyncHigh, pclkRising};
    o.pwr    = {softCtl, preChargeEn, fullDrive, pwmEn, vglPumpEn, cpClkEn, notStandby};
    o.orient = {vglLineRate, cpClkLineRate, vFlip, hFlip};
    o.gam    = gammaPts;
    return o;
  endfunction

  task automatic modelReset();
    m2 = 8'h07; m3 = 8'hD0; m4 = 8'h03;
    for (int h = 0; h < 3; h++) mHi[h] = 8'h00;
    for (int k = 0; k < NG; k++) mLo[k] = 8'h00;
  endtask

  task automatic pushExp(input string tag);
    expQ.push_back(modelObs());
    tagQ.push_back(tag);
    repeat (16) @(negedge clk);
  endtask

  task automatic doReset(input string tag);
    @(negedge clk); rstN = 0;
    repeat (4) @(negedge clk);
    modelReset();
    rstN = 1;
    pushExp(tag);
  endtask

  // nbits < 16 truncates the word; nbits > 16 appends extra ones
  task automatic sendWord(input logic [15:0] w, input int nbits, input string tag);
    @(negedge clk); csN = 0;
    repeat (SCLK_HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b1;
      repeat (SCLK_HALF) @(negedge clk);
      sclk = 1;
      repeat (SCLK_HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (SCLK_HALF) @(negedge clk);
    csN = 1;
    if (nbits >= 16 && w[8]) begin
      case (w[15:10])
        6'd2: m2 = w[7:0];
        6'd3: m3 = w[7:0];
        6'd4: m4 = w[7:0];
        default: begin
          if (w[15:10] >= 6'h11 && w[15:10] <= 6'h13) mHi[w[15:10]-6'h11] = w[7:0];
          else if (w[15:10] >= 6'h14 && w[15:10] <= 6'h1F) mLo[w[15:10]-6'h14] = w[7:0];
        end
      endcase
    end
    pushExp(tag);
  endtask

  function automatic logic [15:0] wr(input logic [5:0] a, input logic [7:0] d);
    return {a, 2'b01, d};
  endfunction

  task automatic cmp(input string tag, input string fld, input logic [NG*GW-1:0] act,
                     input logic [NG*GW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      obs_t e, a;
      string t;
      wait (expQ.size() > 0);
      repeat (10) @(negedge clk);
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = dutObs();
      cmp(t, "scan",   {117'b0, a.scan},   {117'b0, e.scan});
      cmp(t, "pol",    {117'b0, a.pol},    {117'b0, e.pol});
      cmp(t, "pwr",    {113'b0, a.pwr},    {113'b0, e.pwr});
      cmp(t, "orient", {116'b0, a.orient}, {116'b0, e.orient});
      cmp(t, "gamma",  a.gam,              e.gam);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    modelReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    // R9 defaults held during reset
    expQ.push_back(modelObs()); tagQ.push_back("R9");
    repeat (14) @(negedge clk);
    rstN = 1;
    pushExp("R9");
    // R1 / R2 field mapping, bit 9 set as don't-care
    sendWord(wr(6'd2, 8'h35) | 16'h0200, 16, "R1");
    sendWord(wr(6'd2, 8'h0A), 16, "R2");
    // R3
    sendWord(wr(6'd3, 8'h5B), 16, "R3");
    sendWord(wr(6'd3, 8'hCF), 16, "R3");
    // R4
    sendWord(wr(6'd4, 8'h14), 16, "R4");
    sendWord(wr(6'd4, 8'h03), 16, "R4");
    // R5 high bits
    sendWord(wr(6'h11, 8'h9C), 16, "R5");
    sendWord(wr(6'h12, 8'hE4), 16, "R5");
    sendWord(wr(6'h13, 8'h1B), 16, "R5");
    // R6 low bytes
    for (int k = 0; k < NG; k++)
      sendWord(wr(6'(6'h14 + k), 8'(8'h10 + 7*k)), 16, "R6");
    // R7 write flag clear
    sendWord({6'd2, 2'b00, 8'h00}, 16, "R7");
    sendWord({6'h15, 2'b10, 8'hFF}, 16, "R7");
    // R8 cut-short words, then a normal word realigns
    sendWord(wr(6'd3, 8'h00), 10, "R8");
    sendWord(wr(6'd3, 8'h00), 15, "R8");
    sendWord(wr(6'd4, 8'h01), 16, "R8");
    // R10 unmapped addresses
    sendWord(wr(6'h05, 8'hAA), 16, "R10");
    sendWord(wr(6'h10, 8'h55), 16, "R10");
    sendWord(wr(6'h20, 8'hFF), 16, "R10");
    sendWord(wr(6'h3F, 8'h00), 16, "R10");
    // R11 extra edges after 16th bit
    sendWord(wr(6'd2, 8'h21), 20, "R11");
    sendWord(wr(6'd4, 8'h10), 23, "R11");
    // R9 second reset restores defaults
    doReset("R9");
    wait (expQ.size() == 0);
    repeat (12) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule